// File: doc/BRIEF.md
# Pre-Bias Soft-Start Sequencer

This block moves a synchronous rectifier stage from diode rectification to full synchronous rectification without pulling current out of an output that already holds a charge. A digital soft-start level stands in for the charging capacitor. It rises by one step every `CHG_DIV` clocks once a rising edge has arrived on the conditioned PWM input, and it is held at zero while undervoltage, a fault or discharge request, or the external disable is present. Both gate drives stay off until the level reaches an onset value. Past onset, the forward rectifier may follow PWM. The freewheel rectifier receives a window whose start moves earlier in the off phase as the level grows, until the window covers the whole off phase.

The freewheel window comes from a down-counting ramp. The ramp is reloaded to a top value while PWM is high and falls by a fixed step on every clock of the low phase. The window is open while the ramp is below the level's excess over onset. At an excess of zero the width is zero. Once the excess is above the ramp top, the window is fully complementary to PWM. A separate dummy-load enable discharges the output during start-up. It is armed by the first PWM rising edge after undervoltage clears. It stays on while the level is below a second threshold. After the level passes that threshold, it stays on for `DL_HOLD` further PWM rising edges.

Top module: `prebias_softstart`

## Requirements
- R1: While synchronous active-low reset is applied, and on the first cycle after it is released with the other inputs low, `gate_en_o`, `fw_win_o` and `dl_en_o` are all 0.
- R2: The level starts at 0. It increases by one for every `CHG_DIV` clocks counted from the cycle after the first PWM rising edge that arrives while no hold input is high, and it saturates at 2^`LVL_W`-1. `gate_en_o` is 1 exactly when the level is at least `ONSET`.
- R3: While `uvlo_i` is 1, the level is 0 and all three outputs are 0. After `uvlo_i` clears, the level restarts from 0 and needs a new PWM rising edge before it charges.
- R4: The ramp equals `RAMP_TOP` on the first clock of each PWM low phase and drops by `RAMP_STEP` per clock, stopping at 0. `fw_win_o` is 1 only when `pwm_i` is 0, `gate_en_o` is 1, and the ramp is strictly below the level minus `ONSET`. At an excess of 0 the window is therefore empty.
- R5: When the level minus `ONSET` is greater than `RAMP_TOP`, `fw_win_o` equals the inverse of `pwm_i` on every cycle.
- R6: A cycle with `flt_i` at 1 clears the level on the next clock, so `gate_en_o` reads 0 from then on. Charging resumes only after a later PWM rising edge with every hold input at 0.
- R7: `dis_i` at 1 forces the level to 0 in the same way as `flt_i`, and charging restarts on the first PWM rising edge after it is released.
- R8: `dl_en_o` is 1 when `uvlo_i` is 0, a PWM rising edge has been seen since undervoltage last cleared, and the level is below `DL_TH`.
- R9: Once the level is at least `DL_TH`, `dl_en_o` stays 1 until `DL_HOLD` PWM rising edges have been counted at or above that threshold, and then falls to 0.
- R10: PWM rising edges that occur while a hold input is 1 do not arm charging. With no further edge after release, the level and `gate_en_o` stay at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwm_i | input | 1 | Conditioned PWM, already synchronous to clk |
| uvlo_i | input | 1 | Supply undervoltage present |
| flt_i | input | 1 | Discharge request (frequency fault, shutdown detect or missing pulse) |
| dis_i | input | 1 | External disable, forces the level to zero |
| gate_en_o | output | 1 | Gate drives permitted (level at or above onset) |
| fw_win_o | output | 1 | Freewheel gate allowed in this cycle |
| dl_en_o | output | 1 | Dummy-load discharge enable |

## Verification
The bench builds the block with `LVL_W`=6, `CHG_DIV`=2, `ONSET`=4, `RAMP_TOP`=8, `RAMP_STEP`=2, `DL_TH`=20 and `DL_HOLD`=3. With these values the whole start-up, from an empty window through a growing window to a fully complementary one, plus dummy-load release and level saturation, fits in a few hundred clocks. A sweep over every high time from 1 to 4 clocks and every period from 6 to 10 clocks then restarts the sequence after a fault on each pattern. Expected outputs come from an arithmetic count of charging clocks, low-phase clocks and rising edges kept in the bench. Further targeted checks cover fault, disable and undervoltage applied in the middle of a ramp, and edges that arrive during a hold.

// File: rtl/sss_pkg.sv
// Package: shared helpers for the pre-bias soft-start sequencer.
// Assumes: callers pass values that fit in 32 bits.
package sss_pkg;

    // Saturating decrement: v minus s, floored at zero.
    function automatic int unsigned dec_floor(input int unsigned v, input int unsigned s);
        return (v > s) ? (v - s) : 0;
    endfunction

    // Saturating increment: v plus one, capped at lim.
    function automatic int unsigned inc_cap(input int unsigned v, input int unsigned lim);
        return (v >= lim) ? lim : (v + 1);
    endfunction

endpackage

// File: rtl/sss_level.sv
// Module: soft-start level counter.
// Holds a digital level that replaces the start-up capacitor. While any hold
// input is present the level and its prescaler are zero and the block is
// disarmed. A PWM rising edge without hold arms it. Once armed, the level
// climbs by one every CHG_DIV clocks and saturates at full scale.
// Assumes: rise_i is a single-cycle edge pulse synchronous to clk.
module sss_level #(
    parameter int LVL_W   = 8,
    parameter int CHG_DIV = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic             rise_i,
    output logic [LVL_W-1:0] lvl_o
);
    localparam int DW      = (CHG_DIV > 1) ? $clog2(CHG_DIV) : 1;
    localparam int LVL_MAX = (1 << LVL_W) - 1;

    logic [LVL_W-1:0] lvl_q;
    logic [DW-1:0]    div_q;
    logic             armed_q;
    logic             step_en;

    // Prescaler wrap marks a level step.
    assign step_en = (div_q == DW'(CHG_DIV - 1));

    // Arm on a clean edge; disarm on any hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed_q <= 1'b0;
        else if (hold_i)  armed_q <= 1'b0;
        else if (rise_i)  armed_q <= 1'b1;
    end

    // Prescaler runs only while armed and not held.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_i || !armed_q) div_q <= '0;
        else if (step_en)                 div_q <= '0;
        else                              div_q <= div_q + DW'(1);
    end

    // Level discharge on hold, charge by one on each prescaler wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_i)
            lvl_q <= '0;
        else if (armed_q && step_en)
            lvl_q <= LVL_W'(sss_pkg::inc_cap(32'(lvl_q), LVL_MAX));
    end

    assign lvl_o = lvl_q;

    // R2
    lvl_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_i |=> (lvl_q >= $past(lvl_q)));
    // R6
    lvl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (lvl_q == '0));
    // R10
    lvl_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |-> (lvl_q == '0));
endmodule

// File: rtl/sss_ramp.sv
// Module: per-cycle ramp and freewheel window.
// The ramp holds RAMP_TOP while PWM is high. In the low phase it steps down
// by RAMP_STEP per clock, stopping at zero. The freewheel window is open in
// the low phase while the ramp is below the level's excess over onset.
// Assumes: gate_en_i already means lvl_i >= ONSET.
module sss_ramp #(
    parameter int LVL_W     = 8,
    parameter int ONSET     = 32,
    parameter int RAMP_TOP  = 100,
    parameter int RAMP_STEP = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_i,
    input  logic             gate_en_i,
    input  logic [LVL_W-1:0] lvl_i,
    output logic             fw_win_o
);
    localparam int RW = $clog2(RAMP_TOP + 1);
    localparam int CW = ((RW > LVL_W) ? RW : LVL_W) + 1;

    logic [RW-1:0]    ramp_q;
    logic [LVL_W-1:0] span;

    // Reload on high phase, decay on low phase.
    always_ff @(posedge clk) begin
        if (!rst_n || pwm_i) ramp_q <= RW'(RAMP_TOP);
        else                 ramp_q <= RW'(sss_pkg::dec_floor(32'(ramp_q), RAMP_STEP));
    end

    // Excess of the level above onset, zero below onset.
    always_comb begin
        span = gate_en_i ? (lvl_i - LVL_W'(ONSET)) : '0;
    end

    // Window opens once the ramp has fallen below the excess.
    assign fw_win_o = gate_en_i && !pwm_i && (CW'(ramp_q) < CW'(span));

    // R4
    ramp_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_i |=> (ramp_q == RW'(RAMP_TOP)));
    // R4
    ramp_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_i && ramp_q != '0) |=> (ramp_q < $past(ramp_q)));
endmodule

// File: rtl/sss_dload.sv
// Module: dummy-load enable.
// Armed by a PWM rising edge once undervoltage has cleared. On while the
// level is below DL_TH. At or above DL_TH it counts PWM rising edges and
// releases after DL_HOLD of them.
// Assumes: lvl_i is the registered soft-start level.
module sss_dload #(
    parameter int LVL_W   = 8,
    parameter int DL_TH   = 200,
    parameter int DL_HOLD = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             uvlo_i,
    input  logic             rise_i,
    input  logic [LVL_W-1:0] lvl_i,
    output logic             dl_en_o
);
    localparam int HW = $clog2(DL_HOLD + 1);

    logic [HW-1:0] hold_q;
    logic          armed_q;
    logic          above;

    assign above = (lvl_i >= LVL_W'(DL_TH));

    // Arm on first edge after undervoltage clears.
    always_ff @(posedge clk) begin
        if (!rst_n || uvlo_i) armed_q <= 1'b0;
        else if (rise_i)      armed_q <= 1'b1;
    end

    // Reload below threshold, count edges down above it.
    always_ff @(posedge clk) begin
        if (!rst_n || !above)            hold_q <= HW'(DL_HOLD);
        else if (rise_i && hold_q != '0) hold_q <= hold_q - HW'(1);
    end

    assign dl_en_o = !uvlo_i && armed_q && (hold_q != '0);

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (above && !rise_i) |=> $stable(hold_q));
    // R3
    dl_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo_i |=> !armed_q);
endmodule

// File: rtl/prebias_softstart.sv
// Module: pre-bias soft-start sequencer (top).
// Registers PWM for edge detection, merges the hold sources, and joins the
// level counter, the freewheel ramp and the dummy-load enable.
// Assumes: pwm_i is synchronous to clk and ONSET >= 1.
module prebias_softstart #(
    parameter int LVL_W     = 8,
    parameter int CHG_DIV   = 64,
    parameter int ONSET     = 32,
    parameter int RAMP_TOP  = 100,
    parameter int RAMP_STEP = 1,
    parameter int DL_TH     = 200,
    parameter int DL_HOLD   = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_i,
    input  logic uvlo_i,
    input  logic flt_i,
    input  logic dis_i,
    output logic gate_en_o,
    output logic fw_win_o,
    output logic dl_en_o
);
    logic             pwm_q;
    logic             rise;
    logic             hold;
    logic [LVL_W-1:0] lvl;

    // Previous PWM sample for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_q <= 1'b0;
        else        pwm_q <= pwm_i;
    end

    assign rise    = pwm_i && !pwm_q;
    assign hold    = uvlo_i || flt_i || dis_i;
    assign gate_en_o = (lvl >= LVL_W'(ONSET));

    sss_level #(.LVL_W(LVL_W), .CHG_DIV(CHG_DIV)) u_level (
        .clk(clk), .rst_n(rst_n), .hold_i(hold), .rise_i(rise), .lvl_o(lvl));

    sss_ramp #(.LVL_W(LVL_W), .ONSET(ONSET), .RAMP_TOP(RAMP_TOP),
               .RAMP_STEP(RAMP_STEP)) u_ramp (
        .clk(clk), .rst_n(rst_n), .pwm_i(pwm_i), .gate_en_i(gate_en_o),
        .lvl_i(lvl), .fw_win_o(fw_win_o));

    sss_dload #(.LVL_W(LVL_W), .DL_TH(DL_TH), .DL_HOLD(DL_HOLD)) u_dload (
        .clk(clk), .rst_n(rst_n), .uvlo_i(uvlo_i), .rise_i(rise),
        .lvl_i(lvl), .dl_en_o(dl_en_o));

    // R6
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !gate_en_o);
    // R3
    uvlo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo_i |=> (!fw_win_o && !dl_en_o));
endmodule

// File: tb/tb_prebias_softstart.sv
`timescale 1ns/100ps
module tb_prebias_softstart;
    localparam int LVL_W = 6, CHG_DIV = 2, ONSET = 4, RAMP_TOP = 8;
    localparam int RAMP_STEP = 2, DL_TH = 20, DL_HOLD = 3;
    localparam int LVL_MAX = (1 << LVL_W) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic pwm = 1'b0, uvlo = 1'b0, flt = 1'b0, dis = 1'b0;
    logic gate_en, fw_win, dl_en;
    int n_tests = 0, n_fail = 0;
    bit done = 0;

    // bench model state
    int m_chg = 0, m_rk = 0, m_hold = DL_HOLD;
    bit m_seen = 0, m_armed = 0, m_prev = 0;

    always #2.5 clk = ~clk;

    prebias_softstart #(.LVL_W(LVL_W), .CHG_DIV(CHG_DIV), .ONSET(ONSET),
        .RAMP_TOP(RAMP_TOP), .RAMP_STEP(RAMP_STEP), .DL_TH(DL_TH),
        .DL_HOLD(DL_HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .pwm_i(pwm), .uvlo_i(uvlo), .flt_i(flt),
        .dis_i(dis), .gate_en_o(gate_en), .fw_win_o(fw_win), .dl_en_o(dl_en));

    function automatic int m_lvl();
        int v = m_chg / CHG_DIV;
        return (v > LVL_MAX) ? LVL_MAX : v;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0b expected %0b", req, $time, act, exp);
        end
    endtask

    // Compare all outputs against the arithmetic expectation.
    task automatic compare();
        int lv = m_lvl();
        int rmp = RAMP_TOP - m_rk * RAMP_STEP;
        bit g = (lv >= ONSET);
        bit fw;
        if (rmp < 0) rmp = 0;
        fw = g && !pwm && (rmp < lv - ONSET);
        check("R2", gate_en, g);
        check((lv - ONSET > RAMP_TOP) ? "R5" : "R4", fw_win, fw);
        check((lv >= DL_TH) ? "R9" : "R8", dl_en, !uvlo && m_armed && m_hold != 0);
    endtask

    // Advance the model by one clock with the current inputs.
    task automatic model_update();
        bit rise = pwm && !m_prev;
        int lv = m_lvl();
        if (!rst_n) begin
            m_chg = 0; m_seen = 0; m_rk = 0; m_armed = 0; m_hold = DL_HOLD; m_prev = 0;
        end else begin
            if (uvlo || flt || dis) begin m_chg = 0; m_seen = 0; end
            else begin
                if (m_seen) m_chg++;
                if (rise) m_seen = 1;
            end
            m_rk = pwm ? 0 : m_rk + 1;
            if (uvlo) m_armed = 0; else if (rise) m_armed = 1;
            if (lv < DL_TH) m_hold = DL_HOLD;
            else if (rise && m_hold > 0) m_hold--;
            m_prev = pwm;
        end
    endtask

    // Drive pwm, check outputs, then clock once.
    task automatic step(input logic p);
        pwm = p;
        #1;
        if (rst_n) compare();
        model_update();
        @(posedge clk); #1;
    endtask

    task automatic run_pwm(input int periods, input int per, input int hi);
        for (int k = 0; k < periods; k++)
            for (int c = 0; c < per; c++) step(c < hi);
    endtask

    initial begin
        #1;
        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            model_update();
            @(posedge clk); #1;
            check("R1", gate_en | fw_win | dl_en, 1'b0);
        end
        rst_n = 1'b1;
        #1;
        check("R1", gate_en | fw_win | dl_en, 1'b0);
        // R3: undervoltage with PWM running
        uvlo = 1'b1;
        run_pwm(3, 6, 2);
        check("R3", gate_en | dl_en, 1'b0);
        uvlo = 1'b0;
        // full start-up: empty window, growing window, full, dummy-load release
        run_pwm(40, 8, 3);
        check("R5", gate_en, 1'b1);
        check("R9", dl_en, 1'b0);
        // R3: undervoltage mid-run, restart from zero
        uvlo = 1'b1;
        step(1'b0);
        uvlo = 1'b0;
        check("R3", gate_en, 1'b0);
        for (int i = 0; i < 12; i++) step(1'b0);
        check("R3", gate_en, 1'b0);
        run_pwm(10, 8, 3);
        // R6: fault, then idle with no edges
        flt = 1'b1;
        step(1'b1);
        flt = 1'b0;
        check("R6", gate_en, 1'b0);
        for (int i = 0; i < 3 * ONSET * CHG_DIV; i++) step(1'b1);
        check("R6", gate_en, 1'b0);
        run_pwm(8, 8, 3);
        check("R6", gate_en, 1'b1);
        // R7 and R10: edges during disable are ignored
        dis = 1'b1;
        run_pwm(3, 6, 2);
        check("R7", gate_en, 1'b0);
        dis = 1'b0;
        for (int i = 0; i < 3 * ONSET * CHG_DIV; i++) step(1'b0);
        check("R10", gate_en, 1'b0);
        run_pwm(8, 8, 3);
        check("R7", gate_en, 1'b1);
        // sweep of high time and period, restarted by a fault each time
        for (int hi = 1; hi <= 4; hi++)
            for (int per = 6; per <= 10; per++) begin
                flt = 1'b1;
                step(1'b0);
                flt = 1'b0;
                run_pwm(12, per, hi);
            end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule